// File: doc/BRIEF.md
# SPI NOR Command Sequencer

This block is the byte-level command engine of an SPI NOR flash slave. A byte-wide SPI shim hands it one received byte per transfer. It also gives a strobe when chip select becomes active. The sequencer returns one response byte for every byte it accepts. It decodes the first byte after select as an opcode and gathers the address and dummy bytes that follow. It keeps the write-enable latch, answers status and identification queries, and drives a storage engine. That engine serves read data, takes program bytes and carries out erases.

Bit serialisation, multi-lane pin handling and the array itself are handled elsewhere. The manufacturer byte, the device word, the extended identification word and the array size are parameters. The manufacturer byte also sets how many bytes the dual-I/O and quad-I/O reads collect.

Top module: `spi_nor_cmd_seq`

## Requirements
- R1: Reset and every `cs_start` pulse return the sequencer to opcode decode and clear its byte counters. A byte offered in the same cycle as `cs_start` is dropped, and the next byte is decoded as an opcode.
- R2: Every byte accepted on `rx_valid` gives `rsp_valid` for exactly one cycle on the following cycle. The response byte is 0x00 during opcode decode, byte collection and program streaming.
- R3: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 returns one byte with the latch in bit 1 and every other bit 0.
- R4: Opcode 0x9F returns the manufacturer byte, then the device word high byte, then its low byte. When the extended word is nonzero it then also returns that word, high byte first. The byte after the last one is decoded as a new opcode.
- R5: Opcodes 0x03, 0x02, 0xA2, 0x32, 0x20, 0x52 and 0xD8 collect 3 bytes. Opcodes 0x0B, 0x3B and 0x6B collect 4 bytes. The first three collected bytes form the address, most significant first, and any further bytes are dummies.
- R6: Opcode 0xBB collects 4 bytes when the manufacturer byte is 0xEF or 0x01, and 5 bytes otherwise. Opcode 0xEB collects 6 bytes for those manufacturers and 8 bytes otherwise.
- R7: After a read opcode's collection, each byte raises `mem_rd` with `mem_addr` and returns `mem_rdata` on the next cycle. The address then steps by one and wraps to 0 after `ARRAY_BYTES-1`.
- R8: After a program opcode's collection, each byte raises `mem_wr` with `mem_addr` and `mem_wdata` equal to the byte. The address steps by one without wrapping at the array size.
- R9: When collection for an erase opcode ends with the latch set, `erase_req` pulses for one cycle with `mem_addr` holding the address. The kind code is 0 for 0x20, 1 for 0x52 and 2 for 0xD8. With the latch clear, `err` pulses instead and no erase is issued.
- R10: Opcode 0xC7 with the latch set pulses `erase_req` on the next cycle with kind 3. With the latch clear it pulses `err` and issues no erase.
- R11: Opcode 0x01 with the latch clear is ignored, and the next byte is decoded as an opcode. With the latch set, it takes one data byte and then clears the latch.
- R12: An opcode outside the supported set pulses `err` and stays in opcode decode. Opcode 0x00 does nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_start | input | 1 | Chip select has just become active |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| rsp_valid | output | 1 | Response byte present, one cycle after each accepted byte |
| rsp_byte | output | 8 | Response byte |
| mem_rd | output | 1 | Storage read strobe for the current byte |
| mem_wr | output | 1 | Storage program strobe for the current byte |
| mem_addr | output | 24 | Current array address, also the erase address |
| mem_wdata | output | 8 | Byte to program |
| mem_rdata | input | 8 | Storage byte at `mem_addr`, valid in the same cycle |
| erase_req | output | 1 | One-cycle erase request |
| erase_kind | output | 2 | Erase size: 0 small, 1 medium, 2 sector, 3 whole array |
| err | output | 1 | One-cycle pulse on a rejected or unknown command |

## Verification
The storage strobes `mem_rd` and `mem_wr` and their address follow the byte in the same cycle. The bench therefore samples them shortly after driving the byte and before the clock edge. `rsp_byte`, `rsp_valid`, `erase_req` and `err` are registered and appear on the cycle after the accepted byte, so they are sampled half a cycle after the edge that takes the byte. For bulk erase, that is the edge that takes the opcode. For sized erases, it is the edge that takes the last collected byte. Collection lengths are confirmed by checking that the read strobe stays low on the last dummy byte and goes high on the byte after it.

// File: rtl/spi_nor_cmd_seq.sv
module spi_nor_cmd_seq #(
  parameter logic [7:0]  MFR_ID      = 8'h20,
  parameter logic [15:0] DEV_ID      = 16'hBA16,
  parameter logic [15:0] EXT_ID      = 16'h4D00,
  parameter int          ARRAY_BYTES = 1 << 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_start,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic        rsp_valid,
  output logic [7:0]  rsp_byte,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [23:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        erase_req,
  output logic [1:0]  erase_kind,
  output logic        err
);
  localparam logic [23:0] LAST_ADDR = 24'(ARRAY_BYTES - 1);
  localparam bit          SHORT_IO  = (MFR_ID == 8'hEF) || (MFR_ID == 8'h01);
  localparam logic [3:0]  ID_LEN    = (EXT_ID != 16'h0) ? 4'd5 : 4'd3;

  localparam logic [7:0] OP_NOP = 8'h00, OP_WRSR = 8'h01, OP_PP = 8'h02, OP_RD = 8'h03,
    OP_WRDI = 8'h04, OP_RDSR = 8'h05, OP_WREN = 8'h06, OP_FRD = 8'h0B, OP_E4 = 8'h20,
    OP_QPP = 8'h32, OP_DOR = 8'h3B, OP_E32 = 8'h52, OP_QOR = 8'h6B, OP_RDID = 8'h9F,
    OP_DPP = 8'hA2, OP_DIOR = 8'hBB, OP_BULK = 8'hC7, OP_ESEC = 8'hD8, OP_QIOR = 8'hEB;

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_READ, S_COLLECT, S_RESP} state_t;

  state_t      state;
  logic [7:0]  opcode;
  logic [3:0]  need, cnt, need_dec;
  logic [23:0] abuf, cur_addr, addr_nxt;
  logic        wel;
  logic [7:0]  resp_val;
  logic [3:0]  resp_len;

  assign mem_addr  = cur_addr;
  assign mem_wdata = rx_byte;
  assign mem_rd    = rx_valid && !cs_start && state == S_READ;
  assign mem_wr    = rx_valid && !cs_start && state == S_PROG;
  assign addr_nxt  = (cnt < 4'd3) ? {abuf[15:0], rx_byte} : abuf;
  assign resp_len  = (opcode == OP_RDSR) ? 4'd1 : ID_LEN;

  always_comb begin
    case (rx_byte)
      OP_RD, OP_PP, OP_DPP, OP_QPP, OP_E4, OP_E32, OP_ESEC: need_dec = 4'd3;
      OP_FRD, OP_DOR, OP_QOR: need_dec = 4'd4;
      OP_DIOR: need_dec = SHORT_IO ? 4'd4 : 4'd5;
      OP_QIOR: need_dec = SHORT_IO ? 4'd6 : 4'd8;
      OP_WRSR: need_dec = 4'd1;
      default: need_dec = 4'd0;
    endcase
  end

  always_comb begin
    if (opcode == OP_RDSR) resp_val = {6'b0, wel, 1'b0};
    else begin
      case (cnt)
        4'd0:    resp_val = MFR_ID;
        4'd1:    resp_val = DEV_ID[15:8];
        4'd2:    resp_val = DEV_ID[7:0];
        4'd3:    resp_val = EXT_ID[15:8];
        default: resp_val = EXT_ID[7:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; opcode <= OP_NOP; need <= '0; cnt <= '0; abuf <= '0;
      cur_addr <= '0; wel <= 1'b0; rsp_valid <= 1'b0; rsp_byte <= '0;
      erase_req <= 1'b0; erase_kind <= '0; err <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      erase_req <= 1'b0;
      err       <= 1'b0;
      if (cs_start) begin
        state <= S_IDLE;
        cnt   <= '0;
      end else if (rx_valid) begin
        rsp_valid <= 1'b1;
        rsp_byte  <= 8'h00;
        case (state)
          S_IDLE: begin
            opcode <= rx_byte;
            need   <= need_dec;
            cnt    <= '0;
            if (need_dec != 4'd0 && (rx_byte != OP_WRSR || wel)) state <= S_COLLECT;
            case (rx_byte)
              OP_WREN: wel <= 1'b1;
              OP_WRDI: wel <= 1'b0;
              OP_RDSR, OP_RDID: state <= S_RESP;
              OP_BULK: begin
                if (wel) begin
                  erase_req  <= 1'b1;
                  erase_kind <= 2'd3;
                  cur_addr   <= '0;
                end else err <= 1'b1;
              end
              OP_NOP, OP_WRSR, OP_RD, OP_PP, OP_DPP, OP_QPP, OP_E4, OP_E32, OP_ESEC,
              OP_FRD, OP_DOR, OP_QOR, OP_DIOR, OP_QIOR: ;
              default: err <= 1'b1;
            endcase
          end
          S_COLLECT: begin
            if (cnt < 4'd3) abuf <= {abuf[15:0], rx_byte};
            cnt <= cnt + 4'd1;
            if (cnt + 4'd1 == need) begin
              state    <= S_IDLE;
              cur_addr <= addr_nxt;
              case (opcode)
                OP_PP, OP_DPP, OP_QPP: state <= S_PROG;
                OP_RD, OP_FRD, OP_DOR, OP_QOR, OP_DIOR, OP_QIOR: state <= S_READ;
                OP_E4, OP_E32, OP_ESEC: begin
                  if (wel) begin
                    erase_req  <= 1'b1;
                    erase_kind <= (opcode == OP_E4) ? 2'd0 : (opcode == OP_E32) ? 2'd1 : 2'd2;
                  end else err <= 1'b1;
                end
                OP_WRSR: wel <= 1'b0;
                default: ;
              endcase
            end
          end
          S_READ: begin
            rsp_byte <= mem_rdata;
            cur_addr <= (cur_addr >= LAST_ADDR) ? 24'd0 : cur_addr + 24'd1;
          end
          S_PROG: cur_addr <= cur_addr + 24'd1;
          S_RESP: begin
            rsp_byte <= resp_val;
            cnt      <= cnt + 4'd1;
            if (cnt + 4'd1 == resp_len) state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_CS_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_start |=> state == S_IDLE); // R1
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !cs_start |=> rsp_valid); // R2
  AST_PROG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> rsp_byte == 8'h00); // R8
  AST_READ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && cur_addr == LAST_ADDR |=> cur_addr == 24'd0); // R7
  AST_ERASE_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> $past(wel)); // R9
  AST_WRSR_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_COLLECT && opcode == OP_WRSR |-> wel); // R11
  AST_BULK_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req && erase_kind == 2'd3 |-> !err); // R10
endmodule

// File: tb/tb_spi_nor_cmd_seq.sv
module tb_spi_nor_cmd_seq;
  logic clk = 1'b0, rst_n = 1'b0, cs_start = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic rsp_valid, mem_rd, mem_wr, erase_req, err;
  logic [7:0] rsp_byte, mem_wdata, mem_rdata;
  logic [23:0] mem_addr;
  logic [1:0] erase_kind;

  always #2 clk = ~clk;
  assign mem_rdata = mem_addr[7:0] ^ 8'h5A;

  spi_nor_cmd_seq dut (.clk(clk), .rst_n(rst_n), .cs_start(cs_start), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .erase_req(erase_req), .erase_kind(erase_kind), .err(err));

  int total = 0, bad = 0, cycles = 0;
  logic g_rv, g_rd, g_wr, g_er, g_err;
  logic [7:0] g_rsp, g_wd;
  logic [23:0] g_addr, g_eaddr;
  logic [1:0] g_ek;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cs();
    @(negedge clk); cs_start = 1'b1;
    @(negedge clk); cs_start = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    #1 g_rd = mem_rd; g_wr = mem_wr; g_addr = mem_addr; g_wd = mem_wdata;
    @(negedge clk); rx_valid = 1'b0;
    g_rv = rsp_valid; g_rsp = rsp_byte; g_er = erase_req; g_ek = erase_kind;
    g_err = err; g_eaddr = mem_addr;
  endtask

  localparam int NV = 23;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1,8'h05,8'h00}, {1'b0,8'h00,8'h00}, {1'b1,8'h06,8'h00}, {1'b1,8'h05,8'h00},
    {1'b0,8'h00,8'h02}, {1'b1,8'h04,8'h00}, {1'b1,8'h05,8'h00}, {1'b0,8'h00,8'h00},
    {1'b1,8'h9F,8'h00}, {1'b0,8'h00,8'h20}, {1'b0,8'h00,8'hBA}, {1'b0,8'h00,8'h16},
    {1'b0,8'h00,8'h4D}, {1'b0,8'h00,8'h00}, {1'b0,8'h05,8'h00}, {1'b0,8'h00,8'h00},
    {1'b1,8'h03,8'h00}, {1'b0,8'h0F,8'h00}, {1'b0,8'hFF,8'h00}, {1'b0,8'hFE,8'h00},
    {1'b0,8'h00,8'hA4}, {1'b0,8'h00,8'hA5}, {1'b0,8'h00,8'h5A}};

  initial begin
    #1;
    chk("R1 reset rsp_valid", 32'(rsp_valid), 0);
    chk("R1 reset err", 32'(err), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) cs();
      xfer(VEC[i][15:8]);
      chk($sformatf("R2/R3/R4/R7 vec%0d valid", i), 32'(g_rv), 1);
      chk($sformatf("R2/R3/R4/R7 vec%0d byte", i), 32'(g_rsp), 32'(VEC[i][7:0]));
    end

    // R1: select mid-command drops the partial address
    cs(); xfer(8'h03); xfer(8'h00); cs(); xfer(8'h05); xfer(8'h00);
    chk("R1 cs aborts collection", 32'(g_rsp), 0);
    chk("R1 no read after cs", 32'(g_rd), 0);
    // R1: byte in the cs_start cycle is dropped
    @(negedge clk); cs_start = 1'b1; rx_valid = 1'b1; rx_byte = 8'h06;
    @(negedge clk); cs_start = 1'b0; rx_valid = 1'b0;
    chk("R1 byte with cs dropped", 32'(rsp_valid), 0);
    xfer(8'h05); xfer(8'h00);
    chk("R1 wel unchanged", 32'(g_rsp), 0);

    // R8 program without wrap at array size
    cs(); xfer(8'h06); cs(); xfer(8'h02); xfer(8'h0F); xfer(8'hFF); xfer(8'hFF);
    chk("R8 no write while collecting", 32'(g_wr), 0);
    xfer(8'hAA);
    chk("R8 write strobe", 32'(g_wr), 1);
    chk("R8 write addr", 32'(g_addr), 32'h0FFFFF);
    chk("R8 write data", 32'(g_wd), 32'hAA);
    chk("R2 program rsp zero", 32'(g_rsp), 0);
    xfer(8'h55);
    chk("R8 addr past array", 32'(g_addr), 32'h100000);

    // R5 fast read: 3 addr + 1 dummy
    cs(); xfer(8'h0B); xfer(8'h00); xfer(8'h00); xfer(8'h10); xfer(8'hEE);
    chk("R5 dummy not read", 32'(g_rd), 0);
    xfer(8'h00);
    chk("R5 read strobe", 32'(g_rd), 1);
    chk("R5 read addr", 32'(g_addr), 32'h10);
    chk("R7 read data", 32'(g_rsp), 32'h4A);

    // R6 dual-IO read: 5 bytes with this manufacturer
    cs(); xfer(8'hBB); xfer(8'h00); xfer(8'h00); xfer(8'h20); xfer(8'h00); xfer(8'h00);
    chk("R6 dual 5th byte is dummy", 32'(g_rd), 0);
    xfer(8'h00);
    chk("R6 dual read addr", 32'(g_rd ? g_addr : 24'hFFFFFF), 32'h20);
    // R6 quad-IO read: 8 bytes
    cs(); xfer(8'hEB); xfer(8'h00); xfer(8'h00); xfer(8'h30);
    for (int k = 0; k < 5; k++) xfer(8'h00);
    chk("R6 quad 8th byte is dummy", 32'(g_rd), 0);
    xfer(8'h00);
    chk("R6 quad read addr", 32'(g_rd ? g_addr : 24'hFFFFFF), 32'h30);

    // R9 erases with latch set (still set from program test)
    cs(); xfer(8'h20); xfer(8'h01); xfer(8'h23);
    chk("R9 no early erase", 32'(g_er), 0);
    xfer(8'h45);
    chk("R9 small erase req", 32'(g_er), 1);
    chk("R9 small erase kind", 32'(g_ek), 0);
    chk("R9 erase addr", 32'(g_eaddr), 32'h012345);
    cs(); xfer(8'h52); xfer(8'h00); xfer(8'h80); xfer(8'h00);
    chk("R9 medium erase kind", 32'({g_er, g_ek}), 32'b101);
    cs(); xfer(8'hD8); xfer(8'h01); xfer(8'h00); xfer(8'h00);
    chk("R9 sector erase kind", 32'({g_er, g_ek}), 32'b110);
    // R10 bulk erase with latch set
    cs(); xfer(8'hC7);
    chk("R10 bulk erase", 32'({g_er, g_ek, g_err}), 32'b1110);
    // R9/R10 with latch clear
    cs(); xfer(8'h04); cs(); xfer(8'hD8); xfer(8'h00); xfer(8'h00); xfer(8'h00);
    chk("R9 erase rejected", 32'({g_er, g_err}), 32'b01);
    cs(); xfer(8'hC7);
    chk("R10 bulk rejected", 32'({g_er, g_err}), 32'b01);

    // R11 write status ignored when latch clear: 0x06 then decoded as opcode
    cs(); xfer(8'h01); xfer(8'h06); cs(); xfer(8'h05); xfer(8'h00);
    chk("R11 wrsr ignored", 32'(g_rsp), 32'h02);
    // R11 accepted when set, then latch cleared
    cs(); xfer(8'h01); xfer(8'h06); xfer(8'h05); xfer(8'h00);
    chk("R11 wrsr clears latch", 32'(g_rsp), 32'h00);

    // R12 unknown and no-op opcodes
    cs(); xfer(8'h77);
    chk("R12 unknown err", 32'(g_err), 1);
    xfer(8'h00);
    chk("R12 nop no err", 32'(g_err), 0);
    xfer(8'h06); xfer(8'h05); xfer(8'h00);
    chk("R12 still decoding", 32'(g_rsp), 32'h02);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule